// File: doc/BRIEF.md
# Synchronous serial transmitter with post-frame line control

This block shifts one parallel word out on a single serial data line, most significant bit first, in step with a shift clock. As master it makes the shift clock itself from a programmable divider of the system clock. As slave it follows a shift clock supplied from outside, brought into the system clock domain through a two-stage synchronizer.

Once the final bit has been held long enough for the far end to sample it, the block decides what level the data line keeps until the next frame. A two-bit idle select chooses a forced high, a forced low, or keeping the final data bit. A start-condition enable overrides that choice and always returns the line high.

The mode, the divider, the start-condition enable and the idle select are all captured when a frame is accepted. Changing these inputs during a frame has no effect on it.

Top module: `sio_tx_linectl`

## Requirements
- R1: Reset state. After reset the data line is high, the shift clock output is high, and busy and done are low. The data line stays high until the first frame is accepted, whatever the idle select holds.
- R2: Master bit timing. With `master_i`=1, a start accepted on clock edge E0 sends bit `DATA_W-1-i` (most significant first) on the data line for clock edges E0+2H·i through E0+2H·(i+1)-1, where H = `div_i`+1.
  - The shift clock is low for the first H cycles of each bit and high for the last H.
  - The data line changes only together with a falling shift clock.
  - The mode, divider, start-condition enable and idle select are taken from the inputs at the accepting edge.
- R3: Master last-bit hold. In master mode the final bit stays on the line for exactly one bit period (2H cycles). The post-frame level is applied on edge E0+2H·`DATA_W`.
- R4: Slave bit timing. With `master_i`=0, the most significant bit appears on the edge that accepts the start. Each later bit appears only after a synchronized falling edge of `sck_ext_i` that follows a synchronized rising edge.
- R5: Slave last-bit hold. Let L be the length, in system clock cycles, of the low phase of `sck_ext_i` that ends at the final rising edge. The post-frame level is applied on the (L+3)-th system clock edge after that rising edge. This is half a bit period plus the synchronizer delay.
- R6: With the start-condition enable off, idle select 2'b00 drives the line high after the frame.
- R7: With the start-condition enable off, idle select 2'b10 drives the line low after the frame.
- R8: With the start-condition enable off, an idle select whose bit 0 is 1 (2'b01 or 2'b11) keeps the final data bit on the line after the frame.
- R9: With the start-condition enable on, the line goes high after the frame for any idle select.
- R10: A start strobe that arrives while busy is high is ignored. The running frame continues unchanged.
- R11: Busy is high from the accepting edge until the edge that applies the post-frame level. On that edge busy falls and done is high for exactly one cycle.
- R12: The shift clock output is high whenever no master frame is running, including throughout slave frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when not busy |
| data_i | input | DATA_W | Word to send, captured at start |
| master_i | input | 1 | 1 selects master (internal shift clock), 0 selects slave |
| stcond_en_i | input | 1 | Start-condition enable; forces the post-frame level high |
| idle_sel_i | input | 2 | Post-frame level select: 00 high, 10 low, x1 keep final bit |
| div_i | input | DIV_W | Master half bit period minus one, in system clocks |
| sck_ext_i | input | 1 | External shift clock used in slave mode |
| sdo_o | output | 1 | Serial data line |
| sck_o | output | 1 | Shift clock driven in master mode, idles high |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when the post-frame level is applied |

## Verification
The bench aims at the instant the post-frame level takes over, in both modes.

- A master that ends the final bit one half period early or late is caught by the per-cycle checks on the final 2H cycles.
- A slave that measures the low phase wrongly, or counts from the wrong edge, misses the exact (L+3) cycle check.

The idle select is exercised for every code, with final bits of both values and with the start-condition enable on. A decoder that reads bit 1 where bit 0 matters, or that lets the enable lose to the select, drives the wrong level.

A start strobe injected mid-frame, together with changed configuration inputs, exposes a design that restarts or re-reads its settings mid-frame.

Reset with idle select set to low exposes a line that copies the select before any frame has run.

// File: rtl/sio_line_pkg.sv
package sio_line_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic       master;
    logic       stcond;
    logic [1:0] idle_sel;
  } tx_cfg_t;

  // Level the data line takes once the final bit hold has elapsed.
  function automatic logic post_level(input logic       stcond,
                                      input logic [1:0] sel,
                                      input logic       last_bit);
    logic lvl;
    if (stcond)      lvl = 1'b1;
    else if (sel[0]) lvl = last_bit;
    else             lvl = ~sel[1];
    return lvl;
  endfunction

  // Slave hold length: never shorter than one cycle.
  function automatic logic [15:0] hold_len(input logic [15:0] measured);
    return (measured == 16'd0) ? 16'd1 : measured;
  endfunction

endpackage

// File: rtl/sio_sck_sync.sv
module sio_sck_sync #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_ext_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic [CNT_W-1:0] low_len_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // [0] and [1] form the synchronizer, [2] is the edge-detect history
  logic [2:0]       sync_q;
  logic [CNT_W-1:0] low_cnt_q;

  assign rise_o    = sync_q[1] & ~sync_q[2];
  assign fall_o    = ~sync_q[1] & sync_q[2];
  assign low_len_o = low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 3'b111;
      low_cnt_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sck_ext_i};
      if (fall_o)
        low_cnt_q <= CNT_ONE;
      else if (!sync_q[1] && low_cnt_q != CNT_MAX)
        low_cnt_q <= low_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sio_half_timer.sv
module sio_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] limit_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run_i || tick_o)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sio_shift_out.sv
module sio_shift_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              next_bit_o
);
  logic [DATA_W-1:0] sreg_q;

  assign next_bit_o = sreg_q[DATA_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sreg_q <= '0;
    else if (load_i)
      sreg_q <= data_i;
    else if (shift_i)
      sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
  end
endmodule

// File: rtl/sio_tx_linectl.sv
module sio_tx_linectl
  import sio_line_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 8,
  parameter int LOWCNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              master_i,
  input  logic              stcond_en_i,
  input  logic [1:0]        idle_sel_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              sck_ext_i,
  output logic              sdo_o,
  output logic              sck_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0]    LAST_IDX = BIT_W'(DATA_W - 1);
  localparam logic [LOWCNT_W-1:0] HOLD_ONE = LOWCNT_W'(1);

  tx_state_e           state_q;
  tx_cfg_t             cfg_q;
  logic [DIV_W-1:0]    div_q;
  logic [BIT_W-1:0]    bit_idx_q;
  logic                phase_high_q;
  logic                pend_q;
  logic [LOWCNT_W-1:0] hold_cnt_q;
  logic                sdo_q, sck_q, done_q;

  // Named internal events (also observed by the checker)
  logic start_acc, m_tick, m_rise_evt, m_bit_end;
  logic s_rise, s_fall, s_rise_evt, s_fall_evt;
  logic at_last, shift_evt, hold_done, frame_end;
  logic next_bit, post_lvl;
  logic [LOWCNT_W-1:0] low_len, hold_load;
  logic in_master_shift, in_slave_shift;
  logic cfg_master_w, cfg_stcond_w;
  logic [1:0] cfg_sel_w;

  sio_sck_sync #(.CNT_W(LOWCNT_W)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_ext_i (sck_ext_i),
    .rise_o    (s_rise),
    .fall_o    (s_fall),
    .low_len_o (low_len)
  );

  sio_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (in_master_shift),
    .limit_i (div_q),
    .tick_o  (m_tick)
  );

  sio_shift_out #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_acc),
    .data_i     (data_i),
    .shift_i    (shift_evt),
    .next_bit_o (next_bit)
  );

  assign in_master_shift = (state_q == ST_SHIFT) &&  cfg_q.master;
  assign in_slave_shift  = (state_q == ST_SHIFT) && !cfg_q.master;

  assign start_acc  = start_i && (state_q == ST_IDLE);
  assign m_rise_evt = in_master_shift && m_tick && !phase_high_q;
  assign m_bit_end  = in_master_shift && m_tick &&  phase_high_q;
  assign s_rise_evt = in_slave_shift && s_rise;
  assign s_fall_evt = in_slave_shift && s_fall && pend_q;
  assign at_last    = (bit_idx_q == LAST_IDX);
  assign shift_evt  = (m_bit_end && !at_last) || s_fall_evt;
  assign hold_done  = (state_q == ST_HOLD) && (hold_cnt_q <= HOLD_ONE);
  assign frame_end  = (m_bit_end && at_last) || hold_done;
  assign post_lvl   = post_level(cfg_q.stcond, cfg_q.idle_sel, sdo_q);
  assign hold_load  = LOWCNT_W'(hold_len(16'(low_len)));

  assign cfg_master_w = cfg_q.master;
  assign cfg_stcond_w = cfg_q.stcond;
  assign cfg_sel_w    = cfg_q.idle_sel;

  // Frame sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      div_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_acc) begin
          state_q <= ST_SHIFT;
          cfg_q   <= '{master: master_i, stcond: stcond_en_i, idle_sel: idle_sel_i};
          div_q   <= div_i;
        end
        ST_SHIFT: begin
          if (frame_end)                 state_q <= ST_IDLE;
          else if (s_rise_evt && at_last) state_q <= ST_HOLD;
        end
        ST_HOLD: if (hold_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Bit position and half-period phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx_q    <= '0;
      phase_high_q <= 1'b0;
      pend_q       <= 1'b0;
    end else begin
      if (start_acc)      bit_idx_q <= '0;
      else if (shift_evt) bit_idx_q <= bit_idx_q + 1'b1;

      if (start_acc)       phase_high_q <= 1'b0;
      else if (m_rise_evt) phase_high_q <= 1'b1;
      else if (m_bit_end)  phase_high_q <= 1'b0;

      if (start_acc)       pend_q <= 1'b0;
      else if (s_rise_evt) pend_q <= 1'b1;
      else if (s_fall_evt) pend_q <= 1'b0;
    end
  end

  // Slave last-bit hold counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt_q <= '0;
    else if (s_rise_evt && at_last)
      hold_cnt_q <= hold_load;
    else if ((state_q == ST_HOLD) && !hold_done)
      hold_cnt_q <= hold_cnt_q - 1'b1;
  end

  // Line drivers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q  <= 1'b1;
      sck_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      if (start_acc)      sdo_q <= data_i[DATA_W-1];
      else if (shift_evt) sdo_q <= next_bit;
      else if (frame_end) sdo_q <= post_lvl;

      if (start_acc && master_i)                  sck_q <= 1'b0;
      else if (m_rise_evt)                        sck_q <= 1'b1;
      else if (shift_evt && in_master_shift)      sck_q <= 1'b0;

      done_q <= frame_end;
    end
  end

  assign sdo_o  = sdo_q;
  assign sck_o  = sck_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/sio_tx_linectl_chk.sv
module sio_tx_linectl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       sdo_o,
  input logic       sck_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       start_acc,
  input logic       shift_evt,
  input logic       cfg_master,
  input logic       cfg_stcond,
  input logic [1:0] cfg_sel
);
  logic started_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         started_q <= 1'b0;
    else if (start_acc) started_q <= 1'b1;
  end

  assert_reset_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q |-> (sdo_o && sck_o));

  assert_master_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && cfg_master && !$stable(sdo_o)) |-> $fell(sck_o));

  assert_slave_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !cfg_master && !$stable(sdo_o)) |-> $past(shift_evt));

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cfg_stcond && cfg_sel == 2'b00) |-> sdo_o);

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cfg_stcond && cfg_sel == 2'b10) |-> !sdo_o);

  assert_idle_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cfg_stcond && cfg_sel[0]) |-> (sdo_o == $past(sdo_o)));

  assert_stcond_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cfg_stcond) |-> sdo_o);

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |-> !start_acc);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_sck_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o || !cfg_master) |-> sck_o);
endmodule

bind sio_tx_linectl sio_tx_linectl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .sdo_o      (sdo_o),
  .sck_o      (sck_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .start_acc  (start_acc),
  .shift_evt  (shift_evt),
  .cfg_master (cfg_master_w),
  .cfg_stcond (cfg_stcond_w),
  .cfg_sel    (cfg_sel_w)
);

// File: tb/sio_tx_linectl_tb.sv
`timescale 1ns/1ps
module sio_tx_linectl_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          master_i = 1'b0;
  logic          stcond_en_i = 1'b0;
  logic [1:0]    idle_sel_i = 2'b10;
  logic [7:0]    div_i = '0;
  logic          sck_ext_i = 1'b1;
  logic          sdo_o, sck_o, busy_o, done_o;

  int total = 0;
  int bad = 0;
  logic wd_hit = 1'b0;

  always #10 clk = ~clk;

  sio_tx_linectl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .master_i(master_i), .stcond_en_i(stcond_en_i), .idle_sel_i(idle_sel_i),
    .div_i(div_i), .sck_ext_i(sck_ext_i), .sdo_o(sdo_o), .sck_o(sck_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic bit_at(input logic [DW-1:0] d, input int i);
    return d[DW-1-i];
  endfunction

  function automatic logic exp_idle(input logic stc, input logic [1:0] sel, input logic last);
    if (stc) return 1'b1;
    case (sel)
      2'b00:   return 1'b1;
      2'b10:   return 1'b0;
      default: return last;
    endcase
  endfunction

  function automatic string idle_tag(input logic stc, input logic [1:0] sel);
    if (stc) return "R9";
    case (sel)
      2'b00:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic master_frame(input logic [DW-1:0] d, input logic [7:0] dv,
                              input logic stc, input logic [1:0] sel, input bit inject);
    int h = int'(dv) + 1;
    int fr = 2 * h * DW;
    logic lastb = bit_at(d, DW-1);
    @(negedge clk);
    data_i = d; div_i = dv; stcond_en_i = stc; idle_sel_i = sel; master_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // scramble inputs: configuration must have been captured
    data_i = ~d; div_i = dv + 8'd3; stcond_en_i = ~stc; idle_sel_i = ~sel; master_i = 1'b0;
    for (int k = 0; k <= fr + 1; k++) begin
      if (k > 0) @(negedge clk);
      start_i = (inject && k == 2) ? 1'b1 : 1'b0;
      if (k < fr) begin
        chk("R2 data bit", sdo_o, bit_at(d, k / (2*h)));
        chk("R2 shift clock", sck_o, ((k % (2*h)) >= h));
        chk("R11 busy during frame", busy_o, 1'b1);
        if (inject && k == 4) chk("R10 busy kept after ignored start", busy_o, 1'b1);
        if (k == fr - 1) chk("R3 last bit still held", sdo_o, lastb);
      end else if (k == fr) begin
        chk(idle_tag(stc, sel), sdo_o, exp_idle(stc, sel, lastb));
        chk("R3 done at one bit period", done_o, 1'b1);
        chk("R11 busy low at end", busy_o, 1'b0);
        chk("R12 clock idles high", sck_o, 1'b1);
      end else begin
        chk("R11 done single cycle", done_o, 1'b0);
        chk(idle_tag(stc, sel), sdo_o, exp_idle(stc, sel, lastb));
      end
    end
    start_i = 1'b0;
  endtask

  task automatic slave_frame(input logic [DW-1:0] d, input int lo,
                             input logic stc, input logic [1:0] sel);
    logic lastb = bit_at(d, DW-1);
    @(negedge clk);
    data_i = d; stcond_en_i = stc; idle_sel_i = sel; master_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; idle_sel_i = ~sel; stcond_en_i = ~stc;
    chk("R4 first bit at start", sdo_o, bit_at(d, 0));
    chk("R12 clock high in slave", sck_o, 1'b1);
    for (int i = 0; i < DW; i++) begin
      sck_ext_i = 1'b0;
      repeat (lo) @(negedge clk);
      chk("R4 slave bit before rise", sdo_o, bit_at(d, i));
      sck_ext_i = 1'b1;
      if (i < DW - 1) begin
        repeat (lo) @(negedge clk);
        chk("R4 slave bit after rise", sdo_o, bit_at(d, i));
        chk("R12 clock high in slave", sck_o, 1'b1);
      end else begin
        repeat (lo + 2) @(negedge clk);
        chk("R5 last bit held", sdo_o, lastb);
        chk("R5 busy in hold", busy_o, 1'b1);
        @(negedge clk);
        chk("R5 done at hold end", done_o, 1'b1);
        chk(idle_tag(stc, sel), sdo_o, exp_idle(stc, sel, lastb));
        chk("R11 busy low at end", busy_o, 1'b0);
        @(negedge clk);
        chk("R11 done single cycle", done_o, 1'b0);
      end
    end
  endtask

  task automatic run_all();
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 line high after reset", sdo_o, 1'b1);
    chk("R1 clock high after reset", sck_o, 1'b1);
    chk("R1 busy low after reset", busy_o, 1'b0);
    chk("R1 done low after reset", done_o, 1'b0);
    repeat (5) @(negedge clk);
    chk("R1 line stays high before first frame", sdo_o, 1'b1);

    // directed master corners
    master_frame(8'hA5, 8'd0, 1'b0, 2'b00, 1'b0);
    master_frame(8'h3C, 8'd1, 1'b0, 2'b10, 1'b0);
    master_frame(8'h81, 8'd2, 1'b0, 2'b01, 1'b0);
    master_frame(8'h80, 8'd0, 1'b0, 2'b11, 1'b0);
    master_frame(8'hFE, 8'd1, 1'b1, 2'b10, 1'b1);
    master_frame(8'h6B, 8'd3, 1'b0, 2'b10, 1'b1);
    // directed slave corners
    slave_frame(8'hC3, 4, 1'b0, 2'b10);
    slave_frame(8'h57, 6, 1'b0, 2'b01);
    slave_frame(8'h92, 5, 1'b1, 2'b10);
    slave_frame(8'h01, 4, 1'b0, 2'b00);
    // random mix
    for (int n = 0; n < 10; n++)
      master_frame(DW'($urandom), 8'($urandom_range(0, 4)), 1'($urandom),
                   2'($urandom), 1'($urandom));
    for (int n = 0; n < 6; n++)
      slave_frame(DW'($urandom), $urandom_range(4, 9), 1'($urandom), 2'($urandom));
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    if (wd_hit) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule